// File: doc/BRIEF.md
# Parallel NOR Flash Strobe Sequencer

This block turns single-word read and write requests from an internal slave port into the pin-level sequence an external asynchronous parallel NOR flash expects. After a request is accepted, the block asserts the selected chip enable. It then pulses address valid and, on a multiplexed bus, leaves a turnaround gap. Next comes the output-enable or write-enable strobe, followed by a hold phase with chip enable still active. A one-cycle completion pulse ends the access. Every phase length comes from run-time timing inputs. The active level of each strobe and of the ready input is also set at run time.

The external data bus is split into an output value, an output-drive flag and an input value, so that a tristate pad can be built outside the block. The bus can run 16 or 32 bits wide. It can carry address and data on the same pins or keep them apart. Reads may stretch on a device ready signal, which the device raises either together with its data or one cycle before it. Configuration and timing are captured when a request is accepted, so they may change freely between accesses.

Top module: `nor_bus_seq`

## Requirements
- R1: While reset is high, and in the first cycles after it, every chip enable, address valid, output enable and write enable sits at its inactive level. The bus drive flag is 0 and the completion pulse is 0.
- R2: With a phase field value of n, the phase lasts n+1 cycles. Chip enable is active from the first cycle after the request edge. Address valid starts after t_ce+1 chip-enable cycles and stays for t_adv+1 cycles. Chip enable stays active t_hold+1 cycles after the strobe ends.
- R3: Each strobe is at its polarity input's level when active and at the inverse level when inactive. Only the chip-enable bit indexed by the 2-bit select field (bit 0 to bit 3) is ever active.
- R4: In multiplexed mode the bus carries the address only while address valid is active. A turnaround of t_turn+1 cycles follows. On a read the bus is not driven in the cycle before output enable first asserts.
- R5: In separate mode the data bus is never driven during a read, and the strobe begins in the cycle right after address valid ends.
- R6: With the width bit 0, only bus bits 15:0 are driven and captured; bits 31:16 of written bus data and of read results are 0. With the width bit 1, all 32 bits are used.
- R7: On a write with the permit bit 1, write enable is active for t_we+1 cycles while the bus drives the write data. With the permit bit 0, write enable never asserts, but the access still completes with the same timing.
- R8: On a read, output enable lasts t_oe+1 cycles when ready checking is off, and the ready input is then ignored. With checking on, output enable is held until ready is also active. Data is captured at the edge that ends output enable.
- R9: With ready checking on and the early-ready bit 1, output enable is held one more cycle after ready qualifies, and data is captured at the end of that extra cycle.
- R10: The completion pulse is high for exactly one cycle, in the first cycle after chip enable drops. Requests that arrive while an access is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 32-bit bus, 0: 16-bit bus |
| cfg_muxed | input | 1 | 1: address and data share the bus |
| cfg_rdy_en | input | 1 | 1: reads wait for device ready |
| cfg_rdy_early | input | 1 | 1: ready leads data by one cycle |
| cfg_wr_permit | input | 1 | 1: write strobes may reach the device |
| cfg_sel | input | 2 | Device select |
| pol_ce | input | 1 | Chip-enable active level |
| pol_adv | input | 1 | Address-valid active level |
| pol_strobe | input | 1 | Output/write-enable active level |
| pol_rdy | input | 1 | Ready active level |
| tm_ce_setup | input | 4 | Chip-enable setup length minus one |
| tm_adv | input | 4 | Address-valid length minus one |
| tm_turn | input | 4 | Turnaround length minus one |
| tm_hold | input | 4 | Hold length minus one |
| tm_oe | input | 8 | Output-enable length minus one |
| tm_we | input | 8 | Write-enable length minus one |
| req | input | 1 | Access request (taken when idle) |
| req_wr | input | 1 | 1: write, 0: read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| nor_ce | output | 4 | Chip enables |
| nor_adv | output | 1 | Address valid |
| nor_oe | output | 1 | Output enable |
| nor_we | output | 1 | Write enable |
| nor_addr | output | AW | Address pins |
| nor_ad_out | output | DW | Bus output value |
| nor_ad_drive | output | 1 | Bus output drive |
| nor_ad_in | input | DW | Bus input value |
| nor_rdy | input | 1 | Device ready |

## Verification
The bench sweeps every combination of bus width, bus multiplexing and polarity. Within each combination it varies the phase lengths and selected device, and measures the span and start of each strobe against arithmetic sums of the fields. Reads run three ways: with ready ignored, with ready arriving alongside data, and with ready arriving early. The bench's device model returns invalid data until the exact cycle valid data is due, so a capture one cycle early or late shows up as a wrong word. Writes alternate the permit bit to tell a blocked strobe from a shortened one. An extra request issued mid-access shows whether the block starts a second access.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int SHORT_W = 4;
  localparam int LONG_W  = 8;
  localparam int CS_W    = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ADV, PH_TURN, PH_STRB, PH_LATE, PH_HOLD
  } phase_t;

  typedef struct packed {
    logic              wide;
    logic              muxed;
    logic              rdy_en;
    logic              rdy_early;
    logic              wr_permit;
    logic [CS_W-1:0]   sel;
    logic [SHORT_W-1:0] t_ce;
    logic [SHORT_W-1:0] t_adv;
    logic [SHORT_W-1:0] t_turn;
    logic [SHORT_W-1:0] t_hold;
    logic [LONG_W-1:0]  t_oe;
    logic [LONG_W-1:0]  t_we;
  } nor_cfg_t;
endpackage

// File: rtl/nor_phase_fsm.sv
module nor_phase_fsm
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  nor_cfg_t      cfg_in,
  input  logic          rdy_ok,
  input  logic [DW-1:0] ad_in,
  output phase_t        nxt_ph,
  output nor_cfg_t      use_cfg,
  output logic          use_wr,
  output logic [AW-1:0] use_addr,
  output logic [DW-1:0] use_wdata,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LOW_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

  phase_t            ph;
  logic [LONG_W-1:0] cnt, cnt_n;
  nor_cfg_t          cfg_q;
  logic              wr_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic              cap, fin;
  logic              idle;

  assign idle      = (ph == PH_IDLE);
  assign use_cfg   = idle ? cfg_in    : cfg_q;
  assign use_wr    = idle ? req_wr    : wr_q;
  assign use_addr  = idle ? req_addr  : addr_q;
  assign use_wdata = idle ? req_wdata : wdata_q;

  always_comb begin
    nxt_ph = ph;
    cnt_n  = (cnt == '0) ? '0 : cnt - 1'b1;
    cap    = 1'b0;
    fin    = 1'b0;
    case (ph)
      PH_IDLE: if (req) begin
        nxt_ph = PH_SETUP;
        cnt_n  = LONG_W'(cfg_in.t_ce);
      end
      PH_SETUP: if (cnt == '0) begin
        nxt_ph = PH_ADV;
        cnt_n  = LONG_W'(cfg_q.t_adv);
      end
      PH_ADV: if (cnt == '0) begin
        if (cfg_q.muxed) begin
          nxt_ph = PH_TURN;
          cnt_n  = LONG_W'(cfg_q.t_turn);
        end else begin
          nxt_ph = PH_STRB;
          cnt_n  = wr_q ? cfg_q.t_we : cfg_q.t_oe;
        end
      end
      PH_TURN: if (cnt == '0) begin
        nxt_ph = PH_STRB;
        cnt_n  = wr_q ? cfg_q.t_we : cfg_q.t_oe;
      end
      PH_STRB: if (cnt == '0) begin
        if (wr_q) begin
          nxt_ph = PH_HOLD;
          cnt_n  = LONG_W'(cfg_q.t_hold);
        end else if (!cfg_q.rdy_en || rdy_ok) begin
          if (cfg_q.rdy_en && cfg_q.rdy_early) begin
            nxt_ph = PH_LATE;
          end else begin
            cap    = 1'b1;
            nxt_ph = PH_HOLD;
            cnt_n  = LONG_W'(cfg_q.t_hold);
          end
        end
      end
      PH_LATE: begin
        cap    = 1'b1;
        nxt_ph = PH_HOLD;
        cnt_n  = LONG_W'(cfg_q.t_hold);
      end
      PH_HOLD: if (cnt == '0) begin
        nxt_ph = PH_IDLE;
        fin    = 1'b1;
      end
      default: nxt_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      ph   <= nxt_ph;
      cnt  <= cnt_n;
      done <= fin;
      if (idle && req) begin
        cfg_q   <= cfg_in;
        wr_q    <= req_wr;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap) rdata <= cfg_q.wide ? ad_in : (ad_in & LOW_MASK);
    end
  end

  // R8: a read waiting on ready keeps its strobe phase
  a_r8_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_STRB && !wr_q && cfg_q.rdy_en && !rdy_ok) |=> (ph == PH_STRB));
  // R9: the extra early-ready cycle always leads into hold
  a_r9_late_to_hold: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LATE) |=> (ph == PH_HOLD));
  // R10: completion is a single-cycle pulse
  a_r10_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/nor_pin_drv.sv
module nor_pin_drv
  import nor_seq_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 32,
  parameter int NCS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_t          nxt_ph,
  input  logic            muxed,
  input  logic            wide,
  input  logic            wr_permit,
  input  logic [CS_W-1:0] sel,
  input  logic            is_wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            pol_ce,
  input  logic            pol_adv,
  input  logic            pol_strobe,
  output logic [NCS-1:0]  ce_o,
  output logic            adv_o,
  output logic            oe_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_drive
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LOW_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

  logic [NCS-1:0] ce_n, ce_act;
  logic           adv_act, oe_act, we_act, bus_drv;
  logic           busy_n, adv_n, oe_n, we_n, drv_n, wr_data_ph;
  logic [DW-1:0]  mask, bus_n, bus_q;

  assign busy_n = (nxt_ph != PH_IDLE);
  assign mask   = wide ? '1 : LOW_MASK;

  for (genvar i = 0; i < NCS; i++) begin : g_ce
    assign ce_n[i] = busy_n && (sel == CS_W'(i));
    assign ce_o[i] = ~(ce_act[i] ^ pol_ce);
  end

  assign adv_n = (nxt_ph == PH_ADV);
  assign oe_n  = !is_wr && (nxt_ph == PH_STRB || nxt_ph == PH_LATE);
  assign we_n  = is_wr && wr_permit && (nxt_ph == PH_STRB);
  assign wr_data_ph = is_wr && (nxt_ph == PH_TURN || nxt_ph == PH_STRB ||
                      nxt_ph == PH_HOLD ||
                      (!muxed && (nxt_ph == PH_SETUP || nxt_ph == PH_ADV)));

  always_comb begin
    drv_n = 1'b0;
    bus_n = '0;
    if (muxed && adv_n) begin
      drv_n = 1'b1;
      bus_n = DW'(addr) & mask;
    end else if (wr_data_ph) begin
      drv_n = 1'b1;
      bus_n = wdata & mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_act  <= '0;
      adv_act <= 1'b0;
      oe_act  <= 1'b0;
      we_act  <= 1'b0;
      bus_drv <= 1'b0;
      bus_q   <= '0;
      addr_o  <= '0;
    end else begin
      ce_act  <= ce_n;
      adv_act <= adv_n;
      oe_act  <= oe_n;
      we_act  <= we_n;
      bus_drv <= drv_n;
      bus_q   <= bus_n;
      if (busy_n) addr_o <= addr;
    end
  end

  assign adv_o    = ~(adv_act ^ pol_adv);
  assign oe_o     = ~(oe_act ^ pol_strobe);
  assign we_o     = ~(we_act ^ pol_strobe);
  assign ad_o     = bus_q;
  assign ad_drive = bus_drv;

  a_r3_one_chip: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ce_act));
  a_r2_adv_in_ce: assert property (@(posedge clk) disable iff (rst)
    adv_act |-> (ce_act != '0));
  a_r7_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(oe_act && we_act));
  a_r4_release_first: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_act) |-> !$past(bus_drv));
endmodule

// File: rtl/nor_bus_seq.sv
module nor_bus_seq
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wide,
  input  logic               cfg_muxed,
  input  logic               cfg_rdy_en,
  input  logic               cfg_rdy_early,
  input  logic               cfg_wr_permit,
  input  logic [CS_W-1:0]    cfg_sel,
  input  logic               pol_ce,
  input  logic               pol_adv,
  input  logic               pol_strobe,
  input  logic               pol_rdy,
  input  logic [SHORT_W-1:0] tm_ce_setup,
  input  logic [SHORT_W-1:0] tm_adv,
  input  logic [SHORT_W-1:0] tm_turn,
  input  logic [SHORT_W-1:0] tm_hold,
  input  logic [LONG_W-1:0]  tm_oe,
  input  logic [LONG_W-1:0]  tm_we,
  input  logic               req,
  input  logic               req_wr,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_done,
  output logic [DW-1:0]      rsp_rdata,
  output logic [(1<<CS_W)-1:0] nor_ce,
  output logic               nor_adv,
  output logic               nor_oe,
  output logic               nor_we,
  output logic [AW-1:0]      nor_addr,
  output logic [DW-1:0]      nor_ad_out,
  output logic               nor_ad_drive,
  input  logic [DW-1:0]      nor_ad_in,
  input  logic               nor_rdy
);
  localparam int NCS = 1 << CS_W;

  nor_cfg_t      cfg_in, use_cfg;
  phase_t        nxt_ph;
  logic          use_wr;
  logic [AW-1:0] use_addr;
  logic [DW-1:0] use_wdata;
  logic          rdy_ok;

  assign cfg_in = '{wide: cfg_wide, muxed: cfg_muxed, rdy_en: cfg_rdy_en,
                    rdy_early: cfg_rdy_early, wr_permit: cfg_wr_permit,
                    sel: cfg_sel, t_ce: tm_ce_setup, t_adv: tm_adv,
                    t_turn: tm_turn, t_hold: tm_hold, t_oe: tm_oe, t_we: tm_we};
  assign rdy_ok = (nor_rdy == pol_rdy);

  nor_phase_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_in(cfg_in), .rdy_ok(rdy_ok), .ad_in(nor_ad_in),
    .nxt_ph(nxt_ph), .use_cfg(use_cfg), .use_wr(use_wr), .use_addr(use_addr),
    .use_wdata(use_wdata), .done(rsp_done), .rdata(rsp_rdata)
  );

  nor_pin_drv #(.AW(AW), .DW(DW), .NCS(NCS)) u_pins (
    .clk(clk), .rst(rst), .nxt_ph(nxt_ph), .muxed(use_cfg.muxed),
    .wide(use_cfg.wide), .wr_permit(use_cfg.wr_permit), .sel(use_cfg.sel),
    .is_wr(use_wr), .addr(use_addr), .wdata(use_wdata), .pol_ce(pol_ce),
    .pol_adv(pol_adv), .pol_strobe(pol_strobe), .ce_o(nor_ce), .adv_o(nor_adv),
    .oe_o(nor_oe), .we_o(nor_we), .addr_o(nor_addr), .ad_o(nor_ad_out),
    .ad_drive(nor_ad_drive)
  );
endmodule

// File: tb/test_nor_bus_seq.sv
`timescale 1ns/1ps
module test_nor_bus_seq;
  localparam int AW = 20;
  localparam int DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wide = 1, cfg_muxed = 0, cfg_rdy_en = 0, cfg_rdy_early = 0, cfg_wr_permit = 1;
  logic [1:0] cfg_sel = 0;
  logic pol_ce = 1, pol_adv = 1, pol_strobe = 1, pol_rdy = 1;
  logic [3:0] tm_ce_setup = 0, tm_adv = 0, tm_turn = 0, tm_hold = 0;
  logic [7:0] tm_oe = 0, tm_we = 0;
  logic req = 0, req_wr = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [3:0] nor_ce;
  logic nor_adv, nor_oe, nor_we, nor_ad_drive;
  logic [AW-1:0] nor_addr;
  logic [DW-1:0] nor_ad_out;
  logic [DW-1:0] nor_ad_in = 0;
  logic nor_rdy = 0;

  int n_cmp = 0, n_bad = 0;
  int oe_run = 0, k_rdy = 1;
  logic [AW-1:0] dev_addr = 0;

  always #2.5 clk = ~clk;

  nor_bus_seq #(.AW(AW), .DW(DW)) i_nor_bus_seq (.*);

  function automatic logic [31:0] dev_word(input logic [AW-1:0] a);
    return 32'h9E37_0000 + 32'(a) * 32'h0001_0101;
  endfunction

  // device model: ready after k_rdy output-enable cycles, data valid when due
  always @(negedge clk) begin
    int need;
    if (nor_oe == pol_strobe) oe_run = oe_run + 1; else oe_run = 0;
    need = cfg_rdy_en ? k_rdy + int'(cfg_rdy_early) : 1;
    nor_rdy = (cfg_rdy_en && oe_run >= k_rdy) ? pol_rdy : ~pol_rdy;
    nor_ad_in = (oe_run >= need) ? dev_word(dev_addr) : 32'hDEAD_BEEF;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_txn(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd, input bit poke);
    int n_ce = 0, n_adv = 0, f_adv = -1, n_oe = 0, f_oe = -1, n_we = 0, f_we = -1;
    int cs_bad = 0, bus_bad = 0, rel_bad = 0, s_len, start, total;
    bit got = 0, prev_drv = 0;
    logic [31:0] mask, exp_rd;
    mask = cfg_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = wd; dev_addr = a;
    @(negedge clk);
    req = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (poke && i == 1) begin req = 1; req_addr = a ^ 20'h1; end
      if (poke && i == 2) req = 0;
      if (rsp_done) begin
        got = 1;
        chk(nor_ce[cfg_sel] != pol_ce, "R10 done after chip enable drops", 32'(nor_ce), 32'(pol_ce));
      end else begin
        if (nor_ce[cfg_sel] == pol_ce) n_ce++;
        for (int j = 0; j < 4; j++)
          if (j != int'(cfg_sel) && nor_ce[j] != !pol_ce) cs_bad++;
        if (nor_adv == pol_adv) begin
          if (n_adv == 0) f_adv = i;
          n_adv++;
          if (cfg_muxed && !(nor_ad_drive && nor_ad_out == (32'(a) & mask))) bus_bad++;
        end
        if (nor_oe == pol_strobe) begin
          if (n_oe == 0) begin f_oe = i; if (prev_drv) rel_bad++; end
          n_oe++;
        end
        if (nor_we == pol_strobe) begin
          if (n_we == 0) f_we = i;
          n_we++;
          if (!(nor_ad_drive && nor_ad_out == (wd & mask))) bus_bad++;
        end
        if (!wr && !cfg_muxed && nor_ad_drive) bus_bad++;
        prev_drv = nor_ad_drive;
        @(negedge clk);
      end
    end
    s_len = int'(tm_oe) + 1;
    if (cfg_rdy_en) s_len = ((s_len > k_rdy) ? s_len : k_rdy) + int'(cfg_rdy_early);
    start = int'(tm_ce_setup) + int'(tm_adv) + 2 + (cfg_muxed ? int'(tm_turn) + 1 : 0);
    total = start + (wr ? int'(tm_we) + 1 : s_len) + int'(tm_hold) + 1;
    chk(got, "R10 completion seen", 32'(got), 1);
    chk(n_ce == total, "R2 chip-enable span", n_ce, total);
    chk(f_adv == int'(tm_ce_setup) + 1 && n_adv == int'(tm_adv) + 1,
        "R2 address-valid start and length", f_adv * 256 + n_adv,
        (int'(tm_ce_setup) + 1) * 256 + int'(tm_adv) + 1);
    chk(cs_bad == 0, "R3 unselected chip enables inactive", cs_bad, 0);
    if (wr) begin
      if (cfg_wr_permit)
        chk(n_we == int'(tm_we) + 1 && f_we == start, "R7 write strobe", n_we * 256 + f_we,
            (int'(tm_we) + 1) * 256 + start);
      else
        chk(n_we == 0, "R7 blocked write keeps write enable off", n_we, 0);
    end else begin
      chk(n_oe == s_len && f_oe == start, "R8 output-enable start and length",
          n_oe * 256 + f_oe, s_len * 256 + start);
      exp_rd = dev_word(a) & mask;
      chk(rsp_rdata == exp_rd, (cfg_rdy_en && cfg_rdy_early) ? "R9 R6 early-ready capture" :
          "R8 R6 read capture", rsp_rdata, exp_rd);
    end
    chk(bus_bad == 0 && rel_bad == 0, cfg_muxed ? "R4 multiplexed bus use" : "R5 separate bus use",
        bus_bad * 256 + rel_bad, 0);
    for (int j = 0; j < (poke ? 5 : 1); j++) begin
      @(negedge clk);
      chk(nor_ce == {4{!pol_ce}} && !rsp_done && nor_adv != pol_adv &&
          nor_oe != pol_strobe && nor_we != pol_strobe,
          poke ? "R10 request during access ignored" : "R3 idle levels after access",
          {nor_ce, 3'b0, rsp_done}, {{4{!pol_ce}}, 4'b0});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog expired: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state with all polarities active-high
    chk(nor_ce == 4'h0 && !nor_adv && !nor_oe && !nor_we, "R1 strobes inactive in reset",
        {nor_ce, nor_adv, nor_oe, nor_we}, 0);
    chk(!nor_ad_drive && !rsp_done, "R1 bus and done idle in reset", {nor_ad_drive, rsp_done}, 0);
    rst = 0;
    @(negedge clk);
    chk(nor_ce == 4'h0 && !nor_oe && !nor_we && !rsp_done, "R1 idle after reset",
        {nor_ce, nor_oe, nor_we, rsp_done}, 0);
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 2; p++) begin
          cfg_wide = w[0]; cfg_muxed = m[0];
          pol_ce = p[0]; pol_adv = !p[0]; pol_strobe = p[0]; pol_rdy = !p[0];
          for (int v = 0; v < 27; v++) begin
            tm_ce_setup = 4'((v + p) % 3);
            tm_adv      = 4'((v + w) % 3);
            tm_hold     = 4'((v + m) % 4);
            tm_turn     = 4'(v % 3);
            tm_oe       = 8'((v % 3) * (v % 3));
            k_rdy       = 1 + 3 * ((v / 3) % 3);
            cfg_rdy_en  = (v / 9) != 0;
            cfg_rdy_early = (v / 9) == 2;
            cfg_sel     = 2'(v % 4);
            do_txn(1'b0, 20'(v * 4099 + w * 97 + m * 13 + p), 32'h0, v == 5);
          end
          for (int v = 0; v < 4; v++) begin
            cfg_wr_permit = v[0];
            tm_we = v[1] ? 8'd3 : 8'd0;
            tm_ce_setup = 4'(v); tm_adv = 4'(v % 2); tm_hold = 4'(v); tm_turn = 4'(v % 3);
            cfg_sel = 2'(3 - v);
            do_txn(1'b1, 20'(v * 311 + p), 32'hA5C3_0F00 + 32'(v * 16 + w), 1'b0);
          end
          cfg_wr_permit = 1;
        end
    summary();
    $finish;
  end
endmodule